// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of translation entries from memory. A requester hands it a virtual address, a write flag and a user-mode flag over a valid/ready channel. The walker fetches the first-level (directory) entry from the table whose frame is given on `root_frame`, then the second-level (leaf) entry that the directory entry points to. It checks the entries for presence and permission, writes the accessed and dirty flags back to memory where they change, and ends with a one-cycle `done` pulse carrying the physical address or a one-cycle `fault` pulse carrying the fault kind.

The request channel follows valid/ready rules. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from then on until the cycle that carries the `done` or `fault` pulse. The memory side issues one transaction at a time. A request holds its address, data and direction until the memory raises `mem_req_ready`. A read is finished by a later `mem_rsp_valid`. A write is finished at the moment it is accepted.

Entry layout: the frame number sits in bits 31..12. The low bits are present (0), writable (1), user (2), write-through (3), cache-disable (4), accessed (5) and dirty (6). Bits 11..7 are passed through unchanged.

Top module: `xlat_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. After a request is accepted it stays low until the cycle of the outcome pulse. `done` and `fault` are single-cycle pulses and are never high together.
- R2: The directory entry is read at `{root_frame, 12'h000} + vaddr[31:22]*4`. For a present directory entry, the leaf entry is then read at `{dir[31:12], 12'h000} + vaddr[21:12]*4`.
- R3: While `mem_req_ready` is low, a pending memory request keeps valid, address, data and direction stable. At most one read is outstanding. No request is issued while idle.
- R4: If bit 0 (present) of the directory entry is clear, the walk ends in a fault with `fault_kind`=0 and the leaf entry is not read. If bit 0 of the leaf entry is clear, the walk also ends with `fault_kind`=0.
- R5: A write request ends in a fault with `fault_kind`=1 when bit 1 (writable) is clear in either entry.
- R6: A user-mode request ends in a fault with `fault_kind`=1 when bit 2 (user) is clear in either entry. A supervisor request ignores bit 2.
- R7: On success, `paddr` = {leaf[31:12], vaddr[11:0]}, `attr_nocache` = leaf bit 4 and `attr_wthru` = leaf bit 3. These outputs hold until the next success.
- R8: On success, if bit 5 of the directory entry is clear, the entry is written back to its own address with only bit 5 set. No directory write is issued when bit 5 is already set.
- R9: On success, the leaf entry is written back with bit 5 set and, for a write request, bit 6 set. The write happens only if a bit changes, and it comes after any directory write.
- R10: A faulting walk issues no memory writes. `fault_vaddr` captures the request's address and holds it until the next fault.
- R11: After reset, `req_ready`=1, `done`=0, `fault`=0, `mem_req_valid`=0, and `paddr` and `fault_vaddr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, will take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| root_frame | input | 20 | Frame number of the directory table |
| mem_req_valid | output | 1 | Memory transaction pending |
| mem_req_ready | input | 1 | Memory accepts the transaction |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Entry value to write |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 32 | Entry value read |
| done | output | 1 | One-cycle pulse: translation succeeded |
| paddr | output | 32 | Physical address of the last success |
| attr_nocache | output | 1 | Cache-disable flag of the last success |
| attr_wthru | output | 1 | Write-through flag of the last success |
| fault | output | 1 | One-cycle pulse: translation failed |
| fault_kind | output | 1 | 0 = not present, 1 = permission |
| fault_vaddr | output | 32 | Virtual address of the last fault |

## Verification
Some properties are checked on every cycle. The outcome pulses are exclusive and last one cycle. A memory request that is stalled holds still. No request is issued while idle. Every write-back carries the present and accessed flags. On a `done` pulse, the low bits of the physical address equal the request offset. Other behaviour is visible only through whole walks, and the bench's scenarios show it. These cover the entry addresses at both levels, which fault kind each flag combination yields, the absence of writes on faults and the holding of `fault_vaddr`. They also cover the exact write-back values and their order, and the skipped writes when the flags are already set.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int BIT_P  = 0;
  localparam int BIT_W  = 1;
  localparam int BIT_U  = 2;
  localparam int BIT_WT = 3;
  localparam int BIT_CD = 4;
  localparam int BIT_A  = 5;
  localparam int BIT_D  = 6;
  localparam int PERM_W = 3;  // present, writable, user

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_RD,
    ST_DIR_WAIT,
    ST_LEAF_RD,
    ST_LEAF_WAIT,
    ST_DIR_WB,
    ST_LEAF_WB
  } walk_st_t;

  typedef enum logic {
    FK_ABSENT = 1'b0,
    FK_PERM   = 1'b1
  } fault_kind_t;
endpackage

// File: rtl/xlat_entry_addr.sv
module xlat_entry_addr #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int ENT_LG = 2
) (
  input  logic [ADDR_W-OFF_W-1:0] base_frame,
  input  logic [IDX_W-1:0]        idx,
  output logic [ADDR_W-1:0]       addr
);
  localparam int PAD_W = ADDR_W - IDX_W;

  always_comb begin
    addr = {base_frame, {OFF_W{1'b0}}} + ({{PAD_W{1'b0}}, idx} << ENT_LG);
  end
endmodule

// File: rtl/xlat_perm_check.sv
module xlat_perm_check
  import xlat_pkg::*;
(
  input  logic [PERM_W-1:0] dir_flags,
  input  logic [PERM_W-1:0] leaf_flags,
  input  logic              is_write,
  input  logic              is_user,
  output logic              leaf_absent,
  output logic              perm_violation
);
  logic eff_w;
  logic eff_u;

  always_comb begin
    eff_w          = dir_flags[BIT_W] & leaf_flags[BIT_W];
    eff_u          = dir_flags[BIT_U] & leaf_flags[BIT_U];
    leaf_absent    = ~leaf_flags[BIT_P];
    perm_violation = (is_write & ~eff_w) | (is_user & ~eff_u);
  end
endmodule

// File: rtl/xlat_flag_update.sv
module xlat_flag_update
  import xlat_pkg::*;
#(
  parameter int ENT_W = 32
) (
  input  logic [ENT_W-1:0] entry,
  input  logic             mark_dirty,
  output logic [ENT_W-1:0] updated,
  output logic             changed
);
  logic [ENT_W-1:0] set_mask;

  always_comb begin
    set_mask          = '0;
    set_mask[BIT_A]   = 1'b1;
    set_mask[BIT_D]   = mark_dirty;
    updated           = entry | set_mask;
    changed           = (updated != entry);
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int ENT_LG = 2,
  localparam int ADDR_W  = 2 * IDX_W + OFF_W,
  localparam int FRAME_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_vaddr,
  input  logic               req_write,
  input  logic               req_user,
  input  logic [FRAME_W-1:0] root_frame,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_we,
  output logic [ADDR_W-1:0]  mem_req_addr,
  output logic [ADDR_W-1:0]  mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [ADDR_W-1:0]  mem_rsp_rdata,
  output logic               done,
  output logic [ADDR_W-1:0]  paddr,
  output logic               attr_nocache,
  output logic               attr_wthru,
  output logic               fault,
  output logic               fault_kind,
  output logic [ADDR_W-1:0]  fault_vaddr
);
  localparam int DIR_LO  = OFF_W + IDX_W;
  localparam int LEAF_LO = OFF_W;

  walk_st_t          st;
  logic [ADDR_W-1:0] va_q;
  logic              wr_q;
  logic              usr_q;
  logic [ADDR_W-1:0] dir_q;
  logic [ADDR_W-1:0] leaf_q;
  logic              done_q;
  logic              fault_q;
  fault_kind_t       fkind_q;
  logic [ADDR_W-1:0] fva_q;
  logic [ADDR_W-1:0] paddr_q;
  logic              cd_q;
  logic              wt_q;

  logic [ADDR_W-1:0] dir_addr;
  logic [ADDR_W-1:0] leaf_addr;
  logic              leaf_absent;
  logic              perm_bad;
  logic [ADDR_W-1:0] dir_new;
  logic              dir_chg;
  logic [ADDR_W-1:0] leaf_new;
  logic              leaf_chg;

  xlat_entry_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_LG(ENT_LG)) u_dir_addr (
    .base_frame (root_frame),
    .idx        (va_q[DIR_LO +: IDX_W]),
    .addr       (dir_addr)
  );

  xlat_entry_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_LG(ENT_LG)) u_leaf_addr (
    .base_frame (dir_q[ADDR_W-1:OFF_W]),
    .idx        (va_q[LEAF_LO +: IDX_W]),
    .addr       (leaf_addr)
  );

  xlat_perm_check u_perm (
    .dir_flags      (dir_q[PERM_W-1:0]),
    .leaf_flags     (mem_rsp_rdata[PERM_W-1:0]),
    .is_write       (wr_q),
    .is_user        (usr_q),
    .leaf_absent    (leaf_absent),
    .perm_violation (perm_bad)
  );

  xlat_flag_update #(.ENT_W(ADDR_W)) u_dir_upd (
    .entry      (dir_q),
    .mark_dirty (1'b0),
    .updated    (dir_new),
    .changed    (dir_chg)
  );

  xlat_flag_update #(.ENT_W(ADDR_W)) u_leaf_upd (
    .entry      (leaf_q),
    .mark_dirty (wr_q),
    .updated    (leaf_new),
    .changed    (leaf_chg)
  );

  // memory port drive, decoded from state only
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = '0;
    unique case (st)
      ST_DIR_RD: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = dir_addr;
      end
      ST_LEAF_RD: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = leaf_addr;
      end
      ST_DIR_WB: begin
        mem_req_valid = dir_chg;
        mem_req_we    = 1'b1;
        mem_req_addr  = dir_addr;
        mem_req_wdata = dir_new;
      end
      ST_LEAF_WB: begin
        mem_req_valid = leaf_chg;
        mem_req_we    = 1'b1;
        mem_req_addr  = leaf_addr;
        mem_req_wdata = leaf_new;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      dir_q   <= '0;
      leaf_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      fkind_q <= FK_ABSENT;
      fva_q   <= '0;
      paddr_q <= '0;
      cd_q    <= 1'b0;
      wt_q    <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            va_q  <= req_vaddr;
            wr_q  <= req_write;
            usr_q <= req_user;
            st    <= ST_DIR_RD;
          end
        end
        ST_DIR_RD: if (mem_req_ready) st <= ST_DIR_WAIT;
        ST_DIR_WAIT: begin
          if (mem_rsp_valid) begin
            dir_q <= mem_rsp_rdata;
            if (!mem_rsp_rdata[BIT_P]) begin
              fault_q <= 1'b1;
              fkind_q <= FK_ABSENT;
              fva_q   <= va_q;
              st      <= ST_IDLE;
            end else begin
              st <= ST_LEAF_RD;
            end
          end
        end
        ST_LEAF_RD: if (mem_req_ready) st <= ST_LEAF_WAIT;
        ST_LEAF_WAIT: begin
          if (mem_rsp_valid) begin
            leaf_q <= mem_rsp_rdata;
            if (leaf_absent || perm_bad) begin
              fault_q <= 1'b1;
              fkind_q <= leaf_absent ? FK_ABSENT : FK_PERM;
              fva_q   <= va_q;
              st      <= ST_IDLE;
            end else begin
              st <= ST_DIR_WB;
            end
          end
        end
        ST_DIR_WB: if (!dir_chg || mem_req_ready) st <= ST_LEAF_WB;
        ST_LEAF_WB: begin
          if (!leaf_chg || mem_req_ready) begin
            done_q  <= 1'b1;
            paddr_q <= {leaf_q[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]};
            cd_q    <= leaf_q[BIT_CD];
            wt_q    <= leaf_q[BIT_WT];
            st      <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (st == ST_IDLE);
  assign done         = done_q;
  assign fault        = fault_q;
  assign fault_kind   = fkind_q;
  assign fault_vaddr  = fva_q;
  assign paddr        = paddr_q;
  assign attr_nocache = cd_q;
  assign attr_wthru   = wt_q;

  AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && fault)); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R1
  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) fault |=> !fault); // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !mem_req_valid); // R3
  AST_WB_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_wdata[BIT_A] && mem_req_wdata[BIT_P]); // R8
  AST_PADDR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> paddr[OFF_W-1:0] == va_q[OFF_W-1:0]); // R7
endmodule

// File: tb/xlat_walker_tb.sv
`timescale 1ns/1ps
module xlat_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [19:0] root_frame = '0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic        mem_req_we;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;
  logic        done;
  logic [31:0] paddr;
  logic        attr_nocache;
  logic        attr_wthru;
  logic        fault;
  logic        fault_kind;
  logic [31:0] fault_vaddr;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  xlat_walker u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user), .root_frame(root_frame),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .done(done), .paddr(paddr), .attr_nocache(attr_nocache), .attr_wthru(attr_wthru),
    .fault(fault), .fault_kind(fault_kind), .fault_vaddr(fault_vaddr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model
  logic [31:0] cur_pde, cur_pte;
  logic [31:0] rd_addr [4];
  logic [31:0] wr_addr [4];
  logic [31:0] wr_data [4];
  int          nrd = 0, nwr = 0;
  int          proto_err = 0;
  bit          pend = 0;
  int          pend_dly = 0;
  logic [31:0] pend_data;
  bit          stall_prev = 0;
  logic [31:0] held_addr, held_wd;
  logic        held_we;

  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (pend_dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = pend_data;
          pend = 0;
        end else pend_dly--;
      end
      if (stall_prev && (!mem_req_valid || mem_req_addr != held_addr ||
          mem_req_we != held_we || mem_req_wdata != held_wd)) proto_err++;
      if (mem_req_valid && (pend || mem_rsp_valid)) proto_err++;
      mem_req_ready = ($urandom % 4) != 0;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          if (nwr < 4) begin wr_addr[nwr] = mem_req_addr; wr_data[nwr] = mem_req_wdata; end
          nwr++;
        end else begin
          if (nrd < 4) rd_addr[nrd] = mem_req_addr;
          nrd++;
          pend = 1;
          pend_dly = $urandom % 3;
          pend_data = (nrd == 1) ? cur_pde : cur_pte;
        end
      end
      stall_prev = rst_n && mem_req_valid && !mem_req_ready;
      held_addr = mem_req_addr;
      held_we = mem_req_we;
      held_wd = mem_req_wdata;
    end
  end

  logic [31:0] last_fault_va = '0;
  logic [31:0] last_paddr = '0;

  task automatic run_walk(input logic [31:0] va, input bit w, input bit u,
                          input logic [31:0] pde, input logic [31:0] pte, input string tag);
    logic [31:0] da, ta, npte;
    bit e_fault, e_kind;
    int e_rd, e_wr, cnt;
    bit busy_bad;
    logic [31:0] e_wa [2];
    logic [31:0] e_wd [2];
    da = {root_frame, 12'h000} + {20'h0, va[31:22], 2'b00};
    ta = {pde[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
    e_wr = 0;
    e_kind = 0;
    if (!pde[0]) begin e_fault = 1; e_kind = 0; e_rd = 1; end
    else if (!pte[0]) begin e_fault = 1; e_kind = 0; e_rd = 2; end
    else if ((w && !(pde[1] && pte[1])) || (u && !(pde[2] && pte[2]))) begin
      e_fault = 1; e_kind = 1; e_rd = 2;
    end else begin
      e_fault = 0; e_rd = 2;
      if (!pde[5]) begin e_wa[e_wr] = da; e_wd[e_wr] = pde | 32'h20; e_wr++; end
      npte = pte | 32'h20 | (w ? 32'h40 : 32'h0);
      if (npte != pte) begin e_wa[e_wr] = ta; e_wd[e_wr] = npte; e_wr++; end
    end
    cur_pde = pde;
    cur_pte = pte;
    nrd = 0;
    nwr = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_vaddr = va; req_write = w; req_user = u; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    busy_bad = 0;
    cnt = 0;
    while (!(done || fault) && cnt < 3000) begin
      if (req_ready) busy_bad = 1;
      @(negedge clk);
      cnt++;
    end
    if (cnt >= 3000) begin
      chk(0, "R1 walk timeout", 32'(cnt), 32'd3000);
      return;
    end
    chk(!busy_bad && !(done && fault), "R1 busy ready / exclusive pulse", {31'h0, busy_bad}, 32'h0);
    chk(fault == e_fault, {tag, " outcome"}, {31'h0, fault}, {31'h0, e_fault});
    chk(nrd == e_rd, "R2 read count", 32'(nrd), 32'(e_rd));
    if (nrd >= 1) chk(rd_addr[0] == da, "R2 directory address", rd_addr[0], da);
    if (nrd >= 2 && e_rd >= 2) chk(rd_addr[1] == ta, "R2 leaf address", rd_addr[1], ta);
    if (e_fault) begin
      chk(fault_kind == e_kind, {tag, " fault kind"}, {31'h0, fault_kind}, {31'h0, e_kind});
      chk(nwr == 0, "R10 no write on fault", 32'(nwr), 32'h0);
      chk(fault_vaddr == va, "R10 fault address", fault_vaddr, va);
      chk(paddr == last_paddr, "R7 paddr held over fault", paddr, last_paddr);
      last_fault_va = va;
    end else begin
      chk(paddr == {pte[31:12], va[11:0]}, "R7 paddr", paddr, {pte[31:12], va[11:0]});
      chk(attr_nocache == pte[4] && attr_wthru == pte[3], "R7 attributes",
          {30'h0, attr_nocache, attr_wthru}, {30'h0, pte[4], pte[3]});
      chk(fault_vaddr == last_fault_va, "R10 fault address held", fault_vaddr, last_fault_va);
      chk(nwr == e_wr, "R8 R9 write count", 32'(nwr), 32'(e_wr));
      for (int i = 0; i < 2; i++) begin
        if (i < e_wr && i < nwr) begin
          chk(wr_addr[i] == e_wa[i], "R9 write address/order", wr_addr[i], e_wa[i]);
          chk(wr_data[i] == e_wd[i], "R8 R9 write data", wr_data[i], e_wd[i]);
        end
      end
      last_paddr = paddr;
    end
  endtask

  function automatic logic [31:0] rnd_ent(input bit bias_ok);
    logic [31:0] e;
    e = $urandom;
    if (bias_ok) begin
      e[0] = ($urandom % 10) != 0;
      e[1] = ($urandom % 4) != 0;
      e[2] = ($urandom % 4) != 0;
    end
    return e;
  endfunction

  bit finished = 0;

  initial begin
    void'($urandom(32'd7741));
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0 && fault == 1'b0 && mem_req_valid == 1'b0,
        "R11 reset control", {28'h0, req_ready, done, fault, mem_req_valid}, 32'h8);
    chk(paddr == 0 && fault_vaddr == 0, "R11 reset registers", paddr | fault_vaddr, 32'h0);
    rst_n = 1'b1;
    root_frame = 20'h12345;

    // directed corners
    run_walk(32'h0040_1abc, 0, 0, 32'h0000_a006, 32'h0000_b007, "R4 directory absent");
    run_walk(32'h0040_2abc, 0, 0, 32'h0000_a007, 32'h0000_b006, "R4 leaf absent");
    run_walk(32'h0080_3123, 1, 0, 32'h0000_c005, 32'h0000_d007, "R5 directory read-only");
    run_walk(32'h0080_3124, 1, 0, 32'h0000_c007, 32'h0000_d005, "R5 leaf read-only");
    run_walk(32'h0080_3125, 0, 0, 32'h0000_c005, 32'h0000_d005, "R5 read of read-only");
    run_walk(32'hffc0_0fff, 0, 1, 32'h0000_e003, 32'h0000_f007, "R6 user directory supervisor-only");
    run_walk(32'hffc0_1000, 0, 1, 32'h0000_e007, 32'h0000_f003, "R6 user leaf supervisor-only");
    run_walk(32'hffc0_1001, 1, 0, 32'h0000_e003, 32'h0000_f003, "R6 supervisor ignores user bit");
    run_walk(32'h1234_5678, 0, 1, 32'h0000_1027, 32'h0003_3027, "R8 accessed already set");
    run_walk(32'h1234_5679, 1, 1, 32'h0000_1027, 32'h0003_3067, "R9 dirty already set");
    run_walk(32'h1234_567a, 1, 1, 32'h0000_1007, 32'h0003_3007, "R9 write sets accessed and dirty");
    run_walk(32'h1234_567b, 0, 1, 32'h0000_1007, 32'h0003_3017, "R9 read leaves dirty clear");
    run_walk(32'h0000_0000, 0, 0, 32'h0000_0001, 32'hffff_f009, "R7 zero address");

    // constrained random
    for (int n = 0; n < 300; n++) begin
      root_frame = 20'($urandom);
      run_walk($urandom, 1'($urandom), 1'($urandom), rnd_ent(1), rnd_ent(1), "R5 R6 random walk");
    end

    repeat (4) @(negedge clk);
    chk(proto_err == 0, "R3 memory port protocol", 32'(proto_err), 32'h0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL R1 watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule